// File: doc/BRIEF.md
# Sensor Row Readout Timing Generator

This block produces the column-readout timing for one row of a rolling-readout image sensor. A row-start sync arms it. It latches its configuration at that moment and derives a horizontal sequencer clock from the system clock. It then steps a counter of pixel pairs, two pixels per sequencer clock, and holds a pixel-valid strobe high until the programmed count has been covered. A one-cycle end-of-line pulse marks the end of the row.

Each of the two outputs can be moved later by its own delay, counted in sequencer clocks. After each row comes a blanking interval, and its length is tied to the clock-granularity setting. A row-start sync that arrives before blanking has elapsed, or while a row is still running, is ignored. Configuration arrives on parallel inputs.

Top module: `row_readout_timer`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `pix_valid` and `eol` are low. A reset applied in the middle of a row forces both outputs low in the next cycle, and the block then waits for a new sync.
- R2: The 2-bit `gran` code g selects a sequencer period of 2^(g+1) system clocks: 2, 4, 8 or 16 for codes 0, 1, 2 and 3.
- R3: With a valid delay of 0, `pix_valid` rises in the first cycle after the edge that samples an accepted `row_sync`.
- R4: With an end-of-line delay of 0, `eol` is high for exactly one system clock, in the same cycle in which the undelayed `pix_valid` goes low.
- R5: `pix_valid` stays high for (`pix_pairs` + 1) sequencer periods, which carry 2*(`pix_pairs` + 1) pixels. This holds for `pix_pairs` = 0 and for the maximum value.
- R6: `delay_cfg[3:0]` moves both edges of `pix_valid` later by that many sequencer periods.
- R7: `delay_cfg[7:4]` moves `eol` later by that many sequencer periods, independently of the valid delay.
- R8: Blanking lasts 142, 282, 562 or 1122 system clocks for `gran` codes 0, 1, 2 and 3, counted from the undelayed end-of-line cycle. A sync sampled in the last blanking cycle is ignored, and one sampled in the next cycle is accepted.
- R9: `gran`, `pix_pairs` and `delay_cfg` are sampled only when a sync is accepted. Changing them during a row does not alter that row.
- R10: A `row_sync` sampled while a row is being read out produces no output event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high synchronous reset |
| row_sync | input | 1 | Row-start request, sampled on each rising edge |
| gran | input | 2 | Sequencer clock granularity code |
| pix_pairs | input | 8 | Last pixel-pair index of the row |
| delay_cfg | input | 8 | Bits 3:0 valid delay, bits 7:4 end-of-line delay, in sequencer periods |
| pix_valid | output | 1 | Pixel-valid strobe |
| eol | output | 1 | End-of-line pulse, one system clock wide |

## Verification
The two delays can place a strobe edge and the end-of-line pulse in the same system clock. Two cases do this. In the first, a row with equal valid and end-of-line delays makes the falling edge of valid coincide with the pulse. In the second, a single-pair row at the finest granularity uses a valid delay of one and no end-of-line delay, so valid rises in the same cycle as the pulse. The scoreboard orders the expected events of each cycle by kind. A pulse that slips a cycle, or that is swallowed by the valid edge, shows up as an event with the wrong kind or cycle.

// File: rtl/rrt_pkg.sv
`timescale 1ns/1ps
package rrt_pkg;

    // Row sequencing phases of the controller
    typedef enum logic [1:0] {
        RRT_IDLE  = 2'd0,
        RRT_ROW   = 2'd1,
        RRT_BLANK = 2'd2
    } rrt_phase_e;

endpackage

// File: rtl/rrt_divider.sv
`timescale 1ns/1ps
// Sequencer clock enable: one tick every 2^(gran+1) system clocks.
module rrt_divider #(
    parameter int GW  = 2,
    parameter int PHW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic [GW-1:0] gran,
    output logic          tick,
    output logic          phase_zero
);

    typedef struct packed {
        logic [PHW-1:0] phase;
    } div_s;

    div_s       div_d, div_q;
    logic [GW:0]  shift_amt;
    logic [PHW:0] span_m1;

    always_comb begin
        shift_amt  = {1'b0, gran} + (GW+1)'(1);
        span_m1    = ((PHW+1)'(1) << shift_amt) - (PHW+1)'(1);
        tick       = ({1'b0, div_q.phase} == span_m1);
        phase_zero = (div_q.phase == '0);
        div_d      = div_q;
        if (restart || tick) begin
            div_d.phase = '0;
        end else begin
            div_d.phase = div_q.phase + PHW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end

    // R2: the phase never runs past the selected period
    p_phase_range_r2: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, div_q.phase} <= span_m1));

endmodule

// File: rtl/rrt_span.sv
`timescale 1ns/1ps
// Counts sequencer periods since row start; the low part is the pixel-pair index.
module rrt_span #(
    parameter int SEQW = 14
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            restart,
    input  logic            run,
    input  logic            tick,
    output logic [SEQW-1:0] seq
);

    typedef struct packed {
        logic [SEQW-1:0] seq;
    } span_s;

    span_s span_d, span_q;

    always_comb begin
        span_d = span_q;
        if (restart) begin
            span_d.seq = '0;
        end else if (run && tick && (span_q.seq != '1)) begin
            span_d.seq = span_q.seq + SEQW'(1);
        end
        seq = span_q.seq;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            span_q <= '0;
        end else begin
            span_q <= span_d;
        end
    end

    // R5: the period count only moves on a sequencer tick or a restart
    p_seq_moves_on_tick_r5: assert property (@(posedge clk) disable iff (rst)
        (!restart && !tick) |=> $stable(seq));

endmodule

// File: rtl/rrt_blank.sv
`timescale 1ns/1ps
// Row blanking timer: BLANK_UNIT * 2^(gran+1) + BLANK_EXTRA system clocks.
module rrt_blank #(
    parameter int GW          = 2,
    parameter int BLW         = 11,
    parameter int BLANK_UNIT  = 70,
    parameter int BLANK_EXTRA = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [GW-1:0] gran,
    output logic          done
);

    typedef struct packed {
        logic           active;
        logic [BLW-1:0] count;
    } blank_s;

    blank_s       blank_d, blank_q;
    logic [GW:0]  shift_amt;
    logic [BLW-1:0] blank_len;

    always_comb begin
        shift_amt = {1'b0, gran} + (GW+1)'(1);
        blank_len = (BLW'(BLANK_UNIT) << shift_amt) + BLW'(BLANK_EXTRA);
        done      = blank_q.active && (blank_q.count == blank_len - BLW'(1));
        blank_d   = blank_q;
        if (start) begin
            blank_d.active = 1'b1;
            blank_d.count  = '0;
        end else if (done) begin
            blank_d.active = 1'b0;
            blank_d.count  = '0;
        end else if (blank_q.active) begin
            blank_d.count = blank_q.count + BLW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            blank_q <= '0;
        end else begin
            blank_q <= blank_d;
        end
    end

    // R8: the blanking count stays inside the selected interval
    p_blank_bound_r8: assert property (@(posedge clk) disable iff (rst)
        blank_q.active |-> (blank_q.count < blank_len));

endmodule

// File: rtl/rrt_strobe.sv
`timescale 1ns/1ps
// Delayed strobe decode: valid window and end-of-line pulse in sequencer periods.
module rrt_strobe #(
    parameter int PCW  = 8,
    parameter int DVW  = 4,
    parameter int SEQW = 14
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            live,
    input  logic            phase_zero,
    input  logic [SEQW-1:0] seq,
    input  logic [PCW-1:0]  last_pair,
    input  logic [DVW-1:0]  valid_dly,
    input  logic [DVW-1:0]  eol_dly,
    output logic            valid,
    output logic            eol
);

    logic [SEQW-1:0] win_open;
    logic [SEQW-1:0] win_close;
    logic [SEQW-1:0] eol_at;

    always_comb begin
        win_open  = SEQW'(valid_dly);
        win_close = SEQW'(valid_dly) + SEQW'(last_pair) + SEQW'(1);
        eol_at    = SEQW'(eol_dly) + SEQW'(last_pair) + SEQW'(1);
        valid     = live && (seq >= win_open) && (seq < win_close);
        eol       = live && phase_zero && (seq == eol_at);
    end

    // R4: the end-of-line pulse is a single system clock wide
    p_eol_single_r4: assert property (@(posedge clk) disable iff (rst)
        eol |=> !eol);

endmodule

// File: rtl/row_readout_timer.sv
`timescale 1ns/1ps
module row_readout_timer #(
    parameter int PCW         = 8,
    parameter int GW          = 2,
    parameter int DVW         = 4,
    parameter int BLANK_UNIT  = 70,
    parameter int BLANK_EXTRA = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             row_sync,
    input  logic [GW-1:0]    gran,
    input  logic [PCW-1:0]   pix_pairs,
    input  logic [2*DVW-1:0] delay_cfg,
    output logic             pix_valid,
    output logic             eol
);
    import rrt_pkg::*;

    localparam int PHW  = 1 << GW;
    localparam int SEQW = PCW + DVW + 2;
    localparam int BLW  = $clog2(BLANK_UNIT * (1 << PHW) + BLANK_EXTRA + 1);

    typedef struct packed {
        rrt_phase_e     phase;
        logic [GW-1:0]  gran;
        logic [PCW-1:0] last_pair;
        logic [DVW-1:0] valid_dly;
        logic [DVW-1:0] eol_dly;
    } ctl_s;

    ctl_s            ctl_d, ctl_q;
    logic            accept;
    logic            row_done;
    logic            tick;
    logic            phase_zero;
    logic            blank_done;
    logic            live;
    logic [SEQW-1:0] seq;

    always_comb begin
        accept   = (ctl_q.phase == RRT_IDLE) && row_sync;
        row_done = (ctl_q.phase == RRT_ROW) && tick && (seq == SEQW'(ctl_q.last_pair));
        live     = (ctl_q.phase != RRT_IDLE);
        ctl_d    = ctl_q;
        case (ctl_q.phase)
            RRT_IDLE: begin
                if (accept) begin
                    ctl_d.phase     = RRT_ROW;
                    ctl_d.gran      = gran;
                    ctl_d.last_pair = pix_pairs;
                    ctl_d.valid_dly = delay_cfg[DVW-1:0];
                    ctl_d.eol_dly   = delay_cfg[2*DVW-1:DVW];
                end
            end
            RRT_ROW: begin
                if (row_done) begin
                    ctl_d.phase = RRT_BLANK;
                end
            end
            RRT_BLANK: begin
                if (blank_done) begin
                    ctl_d.phase = RRT_IDLE;
                end
            end
            default: ctl_d.phase = RRT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '{phase: RRT_IDLE, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    rrt_divider #(.GW(GW), .PHW(PHW)) u_div (
        .clk        (clk),
        .rst        (rst),
        .restart    (accept),
        .gran       (ctl_q.gran),
        .tick       (tick),
        .phase_zero (phase_zero)
    );

    rrt_span #(.SEQW(SEQW)) u_span (
        .clk     (clk),
        .rst     (rst),
        .restart (accept),
        .run     (live),
        .tick    (tick),
        .seq     (seq)
    );

    rrt_blank #(
        .GW(GW), .BLW(BLW), .BLANK_UNIT(BLANK_UNIT), .BLANK_EXTRA(BLANK_EXTRA)
    ) u_blank (
        .clk   (clk),
        .rst   (rst),
        .start (row_done),
        .gran  (ctl_q.gran),
        .done  (blank_done)
    );

    rrt_strobe #(.PCW(PCW), .DVW(DVW), .SEQW(SEQW)) u_strobe (
        .clk        (clk),
        .rst        (rst),
        .live       (live),
        .phase_zero (phase_zero),
        .seq        (seq),
        .last_pair  (ctl_q.last_pair),
        .valid_dly  (ctl_q.valid_dly),
        .eol_dly    (ctl_q.eol_dly),
        .valid      (pix_valid),
        .eol        (eol)
    );

    // R8: all delayed strobes have finished before blanking ends
    p_quiet_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.phase == RRT_IDLE) |-> (!pix_valid && !eol));

    // R9, R10: latched configuration holds while a row or its blanking runs
    p_cfg_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.phase != RRT_IDLE) |=> ($stable(ctl_q.gran) && $stable(ctl_q.last_pair)
                                     && $stable(ctl_q.valid_dly) && $stable(ctl_q.eol_dly)));

    // R3: an accepted sync opens the valid window at once unless it is delayed
    p_start_valid_r3: assert property (@(posedge clk) disable iff (rst)
        accept |=> (pix_valid || (ctl_q.valid_dly != '0)));

endmodule

// File: tb/sim_row_readout_timer.sv
`timescale 1ns/1ps
module sim_row_readout_timer;

    typedef struct {
        int     kind;   // 0 valid rise, 1 valid fall, 2 end-of-line
        longint at;
        string  req;
    } ev_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       row_sync = 1'b0;
    logic [1:0] gran = 2'd0;
    logic [7:0] pix_pairs = 8'd0;
    logic [7:0] delay_cfg = 8'd0;
    logic       pix_valid;
    logic       eol;

    ev_t    expq[$];
    int     checks = 0;
    int     errors = 0;
    longint cyc = 0;
    longint ready_at = 0;
    bit     mon_en = 1'b0;
    bit     prev_v = 1'b0;

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    row_readout_timer u0 (
        .clk       (clk),
        .rst       (rst),
        .row_sync  (row_sync),
        .gran      (gran),
        .pix_pairs (pix_pairs),
        .delay_cfg (delay_cfg),
        .pix_valid (pix_valid),
        .eol       (eol)
    );

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Monitor: pops the scoreboard as events appear at the ports
    task automatic observe(int kind);
        ev_t e;
        if (expq.size() == 0) begin
            check(1'b0, "R10", $sformatf("unexpected event kind %0d at cycle", kind), cyc, -1);
        end else begin
            e = expq.pop_front();
            check(e.kind == kind, e.req, "event kind", kind, e.kind);
            check(e.at == cyc, e.req, $sformatf("cycle of event kind %0d", e.kind), cyc, e.at);
        end
    endtask

    always @(negedge clk) begin
        if (mon_en) begin
            if (pix_valid && !prev_v) observe(0);
            if (!pix_valid && prev_v) observe(1);
            if (eol) observe(2);
        end
        prev_v = pix_valid;
    end

    // Driver: starts one row and pushes its expected events in time order
    task automatic send_row(int g, int cnt, int dly, string tag,
                            bit poke_mid, bit poke_early, bit chg_mid);
        longint base, div, len, dv, de;
        ev_t    ev[3];
        ev_t    tmp;
        while (cyc < ready_at) @(negedge clk);
        gran      = 2'(g);
        pix_pairs = 8'(cnt);
        delay_cfg = 8'(dly);
        row_sync  = 1'b1;
        base = cyc + 1;
        div  = longint'(1) << (g + 1);
        len  = (cnt + 1) * div;
        dv   = dly & 15;
        de   = (dly >> 4) & 15;
        ev[0] = '{0, base + dv * div,       $sformatf("%s R3 R6", tag)};
        ev[1] = '{1, base + dv * div + len, $sformatf("%s R2 R5", tag)};
        ev[2] = '{2, base + de * div + len, $sformatf("%s R4 R7", tag)};
        for (int i = 0; i < 2; i++) begin
            for (int j = 0; j < 2 - i; j++) begin
                if (ev[j].at * 4 + ev[j].kind > ev[j+1].at * 4 + ev[j+1].kind) begin
                    tmp = ev[j]; ev[j] = ev[j+1]; ev[j+1] = tmp;
                end
            end
        end
        for (int i = 0; i < 3; i++) expq.push_back(ev[i]);
        ready_at = base + len + (70 * div + 2);
        @(negedge clk);
        row_sync = 1'b0;
        if (chg_mid) begin
            gran      = 2'((g + 1) % 4);
            pix_pairs = 8'(cnt + 3);
            delay_cfg = 8'(dly ^ 8'h21);
        end
        if (poke_mid) begin
            @(negedge clk);
            row_sync = 1'b1;
            @(negedge clk);
            row_sync = 1'b0;
        end
        if (poke_early) begin
            while (cyc < ready_at - 1) @(negedge clk);
            row_sync = 1'b1;
            @(negedge clk);
            row_sync = 1'b0;
        end
    endtask

    always @(posedge clk) begin
        if (cyc == 150000) begin
            check(1'b0, "R1", "watchdog expired at cycle", cyc, 150000);
            summary();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check(!pix_valid && !eol, "R1", "outputs during reset", {pix_valid, eol}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!pix_valid && !eol, "R1", "outputs after reset", {pix_valid, eol}, 0);
        mon_en   = 1'b1;
        ready_at = cyc;

        send_row(0, 3,   8'h00, "R3 R4 basic",        0, 0, 0);
        send_row(1, 0,   8'h00, "R5 single pair",     0, 0, 0);
        send_row(2, 5,   8'h03, "R6 valid delay",     0, 0, 0);
        send_row(3, 2,   8'hF0, "R7 eol delay max",   0, 0, 0);
        send_row(0, 7,   8'h52, "R6 R7 both",         0, 0, 0);
        send_row(1, 4,   8'h66, "R4 fall with eol",   0, 0, 0);
        send_row(0, 0,   8'h01, "R4 rise with eol",   0, 1, 0);
        send_row(2, 1,   8'h00, "R8 back to back",    0, 1, 0);
        send_row(3, 0,   8'h11, "R8 coarse",          0, 0, 1);
        send_row(1, 6,   8'h20, "R9 mid change",      1, 0, 0);
        send_row(0, 255, 8'h0F, "R5 max count",       1, 0, 0);

        while (cyc < ready_at + 4) @(negedge clk);
        check(expq.size() == 0, "R10", "events left on scoreboard", expq.size(), 0);

        // Reset in the middle of a row
        mon_en    = 1'b0;
        gran      = 2'd1;
        pix_pairs = 8'd20;
        delay_cfg = 8'h00;
        row_sync  = 1'b1;
        @(negedge clk);
        row_sync = 1'b0;
        repeat (5) @(negedge clk);
        check(pix_valid, "R3", "valid mid-row before reset", pix_valid, 1);
        rst = 1'b1;
        @(negedge clk);
        check(!pix_valid && !eol, "R1", "outputs after mid-row reset", {pix_valid, eol}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!pix_valid && !eol, "R1", "outputs idle after release", {pix_valid, eol}, 0);
        prev_v   = 1'b0;
        mon_en   = 1'b1;
        ready_at = cyc;
        send_row(0, 2, 8'h00, "R1 after reset", 0, 0, 0);
        while (cyc < ready_at + 4) @(negedge clk);
        check(expq.size() == 0, "R10", "events left after final row", expq.size(), 0);
        summary();
    end

endmodule